// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire PHY management bus. Software configures a mode bit (Clause 22 or Clause 45 framing) and a preamble bit, loads sixteen bits of outgoing data, then writes a command word holding a PHY address, a register or device address and a two-bit operation code. That command write launches exactly one serial frame. The block generates the management clock from the system clock, shifts the frame out most significant bit first, releases the data line during the turnaround and data field of read frames, and shifts in the PHY's answer.

Progress is reported inside the two data registers: the register a frame belongs to shows a pending flag while the frame runs and a valid flag once it has finished. A Clause 45 access is made by software as two commands: an address frame that carries the write-data value as the target register number, followed by a read or write frame addressed by device number. An enable bit gates the whole block. Clearing it abandons any frame in progress.

Top module: `mgmt_mdio_master`

## Requirements
- R1: After reset every register reads as zero (byte offsets: command 0x00, write data 0x08, read data 0x10, clock/mode 0x18, enable 0x20; unmapped offsets read zero), MDC is low and the output enable is low.
- R2: A write to offset 0x00 while enabled and idle stores register/device address from bits 4:0, PHY address from bits 12:8 and opcode from bits 17:16 (read back in the same positions) and starts a frame on that clock edge. A read-type frame sets pending (bit 17) and clears valid (bit 16) at offset 0x10; any other frame does so at offset 0x08. At most one pending flag is set.
- R3: With mode bit 24 of offset 0x18 at 0, the frame body is start 01, op 01 for opcode bit 0 = 0 (write) or op 10 for opcode bit 0 = 1 (read), PHY address, register address, then turnaround 10 and the write-data field on writes.
- R4: With mode bit 24 at 1, the start field is 00 and the op field equals the opcode (0 address, 1 write, 2 read with address increment, 3 read). Opcodes 2 and 3 are reads; opcodes 0 and 1 carry the write-data register value as the 16-bit field.
- R5: With bit 12 of offset 0x18 set, 32 one bits precede the body (64 MDC periods in all); with it clear, the frame is the 32-bit body alone.
- R6: On read frames the output enable is low for the last 18 bit times (turnaround and data); on every other bit time of any frame it is high.
- R7: On read frames the 16 data bits are sampled on MDC rising edges, most significant first. When the frame ends, offset 0x10 shows the data in bits 15:0, valid set and pending clear.
- R8: When a write or address frame ends, offset 0x08 shows pending clear and valid set, with its data unchanged.
- R9: A command write while either pending flag is set is ignored: the command register keeps its value and no frame starts. This includes a write in the very cycle the running frame completes.
- R10: MDC is low while idle. Each half period lasts HALF_DIV clock cycles, so pending clears exactly 2*HALF_DIV*N cycles after the launching edge for an N-bit frame. The MDIO output changes only while MDC is low.
- R11: While enable (bit 0 of offset 0x20) is clear, command writes are ignored. Writing enable to 0 clears both pending flags and stops the frame: MDC and output enable return low. Setting enable again allows new frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data input |

## Verification
The completion of a running frame and a new command write can land on the same clock edge: pending is still set as the edge arrives, so the command must be lost, not queued. The bench counts cycles from the launching edge and places a second command write exactly on the edge where the 32-bit frame finishes. Just after that edge it expects pending clear, valid set and the old command still in the register, with MDC then staying low and no further bits on the line.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

    localparam logic [5:0] OFS_CMD  = 6'h00;
    localparam logic [5:0] OFS_WDAT = 6'h08;
    localparam logic [5:0] OFS_RDAT = 6'h10;
    localparam logic [5:0] OFS_CLK  = 6'h18;
    localparam logic [5:0] OFS_EN   = 6'h20;

    typedef struct packed {
        logic [1:0] op;
        logic [4:0] phy;
        logic [4:0] rega;
    } cmd_t;

    // Read-type frame: Clause 45 opcodes 2/3, Clause 22 opcode bit 0 set
    function automatic logic frame_is_read(input logic c45, input logic [1:0] op);
        return c45 ? op[1] : op[0];
    endfunction

    // 32-bit frame body, sent from bit 31 down to bit 0
    function automatic logic [31:0] frame_body(input logic c45, input cmd_t cmd,
                                               input logic [15:0] wdat);
        logic [1:0]  st;
        logic [1:0]  fop;
        logic [1:0]  ta;
        logic [15:0] dat;
        logic        rd;
        rd  = frame_is_read(c45, cmd.op);
        st  = c45 ? 2'b00 : 2'b01;
        fop = c45 ? cmd.op : (cmd.op[0] ? 2'b10 : 2'b01);
        ta  = rd ? 2'b11 : 2'b10;
        dat = rd ? 16'hFFFF : wdat;
        return {st, fop, cmd.phy, cmd.rega, ta, dat};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int HALF_DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] WRAP_AT = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t q, d;
    logic wrap;

    assign wrap     = (q.cnt == WRAP_AT);
    assign rise_evt = run && wrap && !q.mdc;
    assign fall_evt = run && wrap && q.mdc;
    assign mdc      = q.mdc;

    always_comb begin
        d = q;
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (wrap) begin
            d.cnt = '0;
            d.mdc = !q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_MDC_LOW_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !$past(run) |-> !mdc) else $error("MDC high while stopped"); // R10

endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        abort,
    input  logic        c45,
    input  logic        pre,
    input  cmd_t        cmd,
    input  logic [15:0] wdat,
    input  logic        mdc,
    input  logic        rise_evt,
    input  logic        fall_evt,
    input  logic        mdio_i,
    output logic        busy,
    output logic        fin,
    output logic [15:0] rd_data,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam logic [5:0] IDX_PRE  = 6'd63;
    localparam logic [5:0] IDX_BODY = 6'd31;
    localparam logic [5:0] IDX_TA   = 6'd17;
    localparam logic [5:0] IDX_DAT  = 6'd15;

    typedef struct packed {
        logic        busy;
        logic        rd;
        logic [31:0] body;
        logic [5:0]  idx;
        logic [15:0] rdat;
    } eng_t;

    eng_t q, d;
    logic cur_bit;

    assign cur_bit = q.idx[5] ? 1'b1 : q.body[q.idx[4:0]];
    assign busy    = q.busy;
    assign fin     = q.busy && !abort && fall_evt && (q.idx == '0);
    assign rd_data = q.rdat;
    assign mdio_o  = q.busy ? cur_bit : 1'b1;
    assign mdio_oe = q.busy && !(q.rd && (q.idx <= IDX_TA));

    always_comb begin
        d = q;
        if (abort) begin
            d.busy = 1'b0;
        end else if (start && !q.busy) begin
            d.busy = 1'b1;
            d.rd   = frame_is_read(c45, cmd.op);
            d.body = frame_body(c45, cmd, wdat);
            d.idx  = pre ? IDX_PRE : IDX_BODY;
            d.rdat = '0;
        end else if (q.busy) begin
            if (rise_evt && q.rd && (q.idx <= IDX_DAT))
                d.rdat = {q.rdat[14:0], mdio_i};
            if (fall_evt) begin
                if (q.idx == '0) d.busy = 1'b0;
                else             d.idx  = q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_MDIO_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && mdc && $past(mdc) |-> $stable(mdio_o)) else $error("MDIO moved while MDC high"); // R10
    AST_ABORT_STOPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy) else $error("frame continued after abort"); // R11

endmodule

// File: rtl/mgmt_mdio_master.sv
`timescale 1ns/1ps
module mgmt_mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 3,
    parameter int ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    typedef struct packed {
        logic        en;
        logic        c45;
        logic        pre;
        cmd_t        cmd;
        logic [15:0] wdat;
        logic        wval;
        logic        wpend;
        logic [15:0] rdat;
        logic        rval;
        logic        rpend;
    } regs_t;

    regs_t q, d;
    logic [5:0]  addr6;
    logic        any_pend;
    logic        accept;
    cmd_t        new_cmd;
    logic        eng_busy;
    logic        eng_fin;
    logic [15:0] eng_rdata;
    logic        rise_evt;
    logic        fall_evt;
    logic        unused_wdata;

    assign addr6        = 6'(reg_addr);
    assign any_pend     = q.wpend || q.rpend;
    assign new_cmd      = '{op: reg_wdata[17:16], phy: reg_wdata[12:8], rega: reg_wdata[4:0]};
    assign accept       = reg_we && (addr6 == OFS_CMD) && q.en && !any_pend;
    assign unused_wdata = ^{reg_wdata[31:25], reg_wdata[23:18]};

    always_comb begin
        d = q;
        if (eng_fin) begin
            if (q.rpend) begin
                d.rpend = 1'b0;
                d.rval  = 1'b1;
                d.rdat  = eng_rdata;
            end else begin
                d.wpend = 1'b0;
                d.wval  = 1'b1;
            end
        end
        if (reg_we) begin
            case (addr6)
                OFS_WDAT: d.wdat = reg_wdata[15:0];
                OFS_CLK: begin
                    d.c45 = reg_wdata[24];
                    d.pre = reg_wdata[12];
                end
                OFS_EN: begin
                    d.en = reg_wdata[0];
                    if (!reg_wdata[0]) begin
                        d.wpend = 1'b0;
                        d.rpend = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (accept) begin
            d.cmd = new_cmd;
            if (frame_is_read(q.c45, new_cmd.op)) begin
                d.rpend = 1'b1;
                d.rval  = 1'b0;
            end else begin
                d.wpend = 1'b1;
                d.wval  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (addr6)
            OFS_CMD:  reg_rdata = {14'b0, q.cmd.op, 3'b0, q.cmd.phy, 3'b0, q.cmd.rega};
            OFS_WDAT: reg_rdata = {14'b0, q.wpend, q.wval, q.wdat};
            OFS_RDAT: reg_rdata = {14'b0, q.rpend, q.rval, q.rdat};
            OFS_CLK:  reg_rdata = {7'b0, q.c45, 11'b0, q.pre, 12'b0};
            OFS_EN:   reg_rdata = {31'b0, q.en};
            default:  reg_rdata = '0;
        endcase
    end

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (eng_busy),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_eng u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .abort    (!q.en),
        .c45      (q.c45),
        .pre      (q.pre),
        .cmd      (new_cmd),
        .wdat     (q.wdat),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (eng_busy),
        .fin      (eng_fin),
        .rd_data  (eng_rdata),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.wpend && q.rpend)) else $error("both pending flags set"); // R2
    AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && (addr6 == OFS_CMD) && any_pend |=> $stable(q.cmd)) else $error("command taken while busy"); // R9
    AST_RD_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rpend) && q.en |-> q.rval) else $error("read ended without valid"); // R7
    AST_PEND_TRACKS_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
        q.en && any_pend |-> eng_busy) else $error("pending without a frame"); // R2

endmodule

// File: tb/sim_mgmt_mdio_master.sv
`timescale 1ns/1ps
module sim_mgmt_mdio_master;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int errs = 0;
    int checks = 0;
    logic [63:0] cap_o = '0;
    logic [63:0] cap_oe = '0;
    int nb_all = 0;
    int base = 0;
    int total = 32;
    logic [15:0] resp = '0;

    always #5 clk = ~clk;

    mgmt_mdio_master #(.HALF_DIV(HALF), .ADDR_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: record each bit at MDC rise, answer reads after MDC fall
    always @(posedge mdc) begin
        cap_o  = {cap_o[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
        nb_all = nb_all + 1;
    end
    always @(negedge mdc) begin
        int n;
        n = nb_all - base;
        if (n >= total - 16 && n < total) mdio_i = resp[total - 1 - n];
        else mdio_i = 1'b1;
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [5:0] a, input logic [31:0] dt);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = dt;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [5:0] a, output logic [31:0] dt);
        @(negedge clk);
        reg_addr = a;
        #1 dt = reg_rdata;
    endtask

    function automatic logic [31:0] cmdw(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
        return {14'b0, op, 3'b0, phy, 3'b0, ra};
    endfunction

    task automatic wait_idle();
        logic [31:0] a, b;
        for (int i = 0; i < 4000; i++) begin
            reg_rd(6'h08, a);
            reg_rd(6'h10, b);
            if (!a[17] && !b[17]) break;
        end
    endtask

    task automatic run_frame(input logic [31:0] cmd, input int n, input logic [15:0] rsp);
        base = nb_all; total = n; resp = rsp;
        reg_wr(6'h00, cmd);
        wait_idle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a <= 40; a += 8) begin
            reg_rd(6'(a), v);
            chk("R1", $sformatf("reset value at %0h", a), v, 0);
        end
        chk("R1", "reset mdc", mdc, 0);
        chk("R1", "reset oe", mdio_oe, 0);
    endtask

    task automatic t_c22_write();
        logic [31:0] v;
        reg_wr(6'h20, 32'h1);
        reg_wr(6'h18, 32'h0);
        reg_wr(6'h08, 32'hA5C3);
        base = nb_all; total = 32;
        reg_wr(6'h00, cmdw(2'd0, 5'd5, 5'h11));
        reg_rd(6'h08, v);
        chk("R2", "write pending after launch", v[17:16], 2'b10);
        reg_rd(6'h00, v);
        chk("R2", "command readback", v, cmdw(2'd0, 5'd5, 5'h11));
        wait_idle();
        chk("R5", "bits without preamble", nb_all - base, 32);
        chk("R3", "c22 write body", cap_o[31:0], {2'b01, 2'b01, 5'd5, 5'h11, 2'b10, 16'hA5C3});
        chk("R6", "oe on write", cap_oe[31:0], 32'hFFFF_FFFF);
        reg_rd(6'h08, v);
        chk("R8", "write done flags", v, 32'h1_A5C3);
    endtask

    task automatic t_c22_read();
        logic [31:0] v;
        reg_wr(6'h18, 32'h1000);
        run_frame(cmdw(2'd1, 5'h1F, 5'd2), 64, 16'h3C5A);
        chk("R5", "bits with preamble", nb_all - base, 64);
        chk("R5", "preamble ones", cap_o[63:32], 32'hFFFF_FFFF);
        chk("R3", "c22 read header", cap_o[31:18], {2'b01, 2'b10, 5'h1F, 5'd2});
        chk("R6", "oe released on read", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
        reg_rd(6'h10, v);
        chk("R7", "read data flags", v, 32'h1_3C5A);
    endtask

    task automatic t_c45();
        logic [31:0] v;
        reg_wr(6'h18, 32'h0100_1000);
        reg_wr(6'h08, 32'hC003);
        run_frame(cmdw(2'd0, 5'd3, 5'd4), 64, 16'h0);
        chk("R4", "c45 address frame", cap_o[31:0], {2'b00, 2'b00, 5'd3, 5'd4, 2'b10, 16'hC003});
        run_frame(cmdw(2'd3, 5'd3, 5'd4), 64, 16'h1234);
        chk("R4", "c45 read header", cap_o[31:18], {2'b00, 2'b11, 5'd3, 5'd4});
        reg_rd(6'h10, v);
        chk("R7", "c45 read data", v, 32'h1_1234);
        run_frame(cmdw(2'd2, 5'd9, 5'd1), 64, 16'h8001);
        chk("R4", "c45 read-increment header", cap_o[31:18], {2'b00, 2'b10, 5'd9, 5'd1});
        chk("R6", "oe on read-increment", cap_oe[17:0], 18'h0);
        reg_rd(6'h10, v);
        chk("R7", "read-increment data", v, 32'h1_8001);
        reg_wr(6'h08, 32'hBEEF);
        run_frame(cmdw(2'd1, 5'd3, 5'd4), 64, 16'h0);
        chk("R4", "c45 write frame", cap_o[31:0], {2'b00, 2'b01, 5'd3, 5'd4, 2'b10, 16'hBEEF});
        reg_rd(6'h08, v);
        chk("R8", "c45 write done", v, 32'h1_BEEF);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        reg_wr(6'h18, 32'h0);
        reg_wr(6'h08, 32'h0F0F);
        base = nb_all; total = 32;
        reg_wr(6'h00, cmdw(2'd0, 5'd7, 5'd8));
        reg_wr(6'h00, cmdw(2'd1, 5'd1, 5'd1));
        reg_rd(6'h00, v);
        chk("R9", "command kept while busy", v, cmdw(2'd0, 5'd7, 5'd8));
        reg_rd(6'h10, v);
        chk("R9", "no read pending from ignored command", v[17], 0);
        wait_idle();
        repeat (20) @(negedge clk);
        chk("R9", "one frame only", nb_all - base, 32);
        chk("R9", "frame from first command", cap_o[31:0], {2'b01, 2'b01, 5'd7, 5'd8, 2'b10, 16'h0F0F});
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        int hi;
        base = nb_all; total = 32;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'h00; reg_wdata = cmdw(2'd0, 5'd2, 5'd6);
        @(negedge clk);
        reg_we = 1'b0;
        repeat (2 * HALF * 32 - 1) @(negedge clk);
        reg_addr = 6'h08;
        #1 v = reg_rdata;
        chk("R10", "pending one cycle before end", v[17], 1);
        reg_addr = 6'h00; reg_wdata = cmdw(2'd1, 5'd4, 5'd4); reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 6'h08;
        #1 v = reg_rdata;
        chk("R10", "pending clear at end cycle", v[17:16], 2'b01);
        reg_addr = 6'h00;
        #1 v = reg_rdata;
        chk("R9", "command at completion edge ignored", v, cmdw(2'd0, 5'd2, 5'd6));
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mdc) hi++;
        end
        chk("R10", "mdc idle low after end", hi, 0);
        chk("R9", "no frame after completion-edge command", nb_all - base, 32);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        int hi;
        reg_wr(6'h18, 32'h1000);
        base = nb_all; total = 64;
        reg_wr(6'h00, cmdw(2'd1, 5'd1, 5'd1));
        repeat (30) @(negedge clk);
        reg_wr(6'h20, 32'h0);
        repeat (4) @(negedge clk);
        chk("R11", "mdc low after disable", mdc, 0);
        chk("R11", "oe low after disable", mdio_oe, 0);
        reg_rd(6'h10, v);
        chk("R11", "read pending cleared", v[17], 0);
        base = nb_all;
        reg_wr(6'h00, cmdw(2'd0, 5'd1, 5'd1));
        hi = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (mdc) hi++;
        end
        reg_rd(6'h08, v);
        chk("R11", "command ignored while disabled", {v[17], 8'(hi)}, 9'h0);
        reg_wr(6'h20, 32'h1);
        reg_wr(6'h18, 32'h0);
        reg_wr(6'h08, 32'h5555);
        run_frame(cmdw(2'd0, 5'd1, 5'd3), 32, 16'h0);
        chk("R11", "frame after re-enable", cap_o[31:0], {2'b01, 2'b01, 5'd1, 5'd3, 2'b10, 16'h5555});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_c22_write();
        t_c22_read();
        t_c45();
        t_busy_ignore();
        t_same_cycle();
        t_disable();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule